// File: doc/BRIEF.md
# Iterative Integer Divide and Remainder Unit

This block computes the quotient or remainder of two integers for a 64-bit processor pipeline. One request carries a dividend, a divisor, a 3-bit function code and a word-form flag. It returns a 64-bit result one cycle wide. The full-width forms work on all 64 bits. The word forms work on the low 32 bits of each operand and return a 32-bit result sign-extended to 64 bits. The unit never traps. Division by zero and signed overflow return fixed architectural values.

The datapath is a radix-2 restoring divider. It works on unsigned magnitudes, and the signs are corrected at the output. The divider takes one quotient bit per clock. A full-width operation takes 64 iterations and a word-form operation takes 32. Division by zero and signed overflow are detected at the input and finish at once, through the same handshake. The unit holds one operation at a time. `req_ready` is low from acceptance until the result pulse has ended.

Top module: `div_unit`

## Requirements
- R1: `req_func` selects the operation. 3'b100 is a signed quotient, 3'b101 an unsigned quotient, 3'b110 a signed remainder and 3'b111 an unsigned remainder. Bit 1 picks remainder over quotient and bit 0 picks unsigned over signed. `req_word`=1 selects the 32-bit form of the same operation.
- R2: A signed quotient rounds toward zero. A signed remainder takes the sign of the dividend. Unsigned forms treat operands as plain binary magnitudes.
- R3: With a zero divisor, every quotient form returns all ones.
- R4: With a zero divisor, every remainder form returns the dividend. In word form this is the low 32 bits of the dividend, sign-extended, for both signed and unsigned.
- R5: A signed quotient of the most negative value by -1 returns the most negative value. The matching signed remainder returns 0. In word form the most negative value is 0x80000000, sign-extended. A signed remainder by -1 is always 0.
- R6: Word forms read only bits [31:0] of each operand. The upper bits have no effect on the result.
- R7: Every word-form result, including the unsigned forms, is bits [31:0] of the 32-bit result sign-extended to 64 bits.
- R8: `req_ready` is high when the unit is idle. A request is taken on a rising edge with `req_valid` and `req_ready` both high. `req_ready` stays low until the edge that ends the result cycle. `rsp_valid` is high for exactly one cycle, and `req_ready` is high again in the following cycle. After reset, `req_ready`=1 and `rsp_valid`=0.
- R9: For an ordinary operation, `rsp_valid` rises on the 64th rising edge after the accepting edge, or on the 32nd for a word form. A zero divisor or a signed overflow raises `rsp_valid` on the accepting edge itself.
- R10: While an operation is in progress, changes on `req_func`, `req_word`, `req_dividend`, `req_divisor` and `req_valid` do not affect its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_func | input | 3 | Function code; bit 2 is set for all defined codes and is not decoded |
| req_word | input | 1 | Select the 32-bit word form |
| req_dividend | input | 64 | Dividend operand |
| req_divisor | input | 64 | Divisor operand |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_result | output | 64 | Result, meaningful while rsp_valid is high, zero otherwise |

## Verification
Two functions can land in the same cycle: the result strobe of one operation and a new request waiting on `req_valid`. The bench provokes this by holding `req_valid` high through the whole busy period. During the first cycles the held request carries changing operands. For the rest of the busy period, including the result cycle, it carries a second operation. The first result must match the operands captured at acceptance. The second operation must not be taken during the result cycle. It must be taken on the edge after it, and it must then finish with its own correct result and latency.

// File: rtl/div_pkg.sv
// Shared types for the divide unit.
package div_pkg;

    // Controller states: waiting, iterating, presenting the result.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } div_state_e;

    // Per-operation attributes captured when a request is accepted.
    typedef struct packed {
        logic word;     // 32-bit form selected
        logic is_rem;   // remainder wanted instead of quotient
        logic q_neg;    // quotient must be negated at the end
        logic r_neg;    // remainder must be negated at the end
        logic special;  // zero divisor or signed overflow, result is fixed
    } div_op_t;

endpackage

// File: rtl/div_prep.sv
// Operand preparation.
// Picks the effective operands for the full-width or word form, turns
// them into unsigned magnitudes and records the sign fix-ups. It also
// detects a zero divisor and signed overflow and gives their fixed
// result. Purely combinational. Assumes W is even.
module div_prep
    import div_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [1:0]   func_lo,
    input  logic         word,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] mag_a,
    output logic [W-1:0] mag_b,
    output div_op_t      op,
    output logic [W-1:0] special_val
);
    localparam int HALF = W / 2;

    logic         sgn;
    logic         is_rem;
    logic [W-1:0] ea;
    logic [W-1:0] eb;
    logic [W-1:0] min_eff;
    logic         neg_a;
    logic         neg_b;
    logic         b_zero;
    logic         ovf;

    // Select the effective operands and the most negative value for the form.
    always_comb begin
        sgn    = ~func_lo[0];
        is_rem = func_lo[1];
        if (word) begin
            ea      = sgn ? {{HALF{dividend[HALF-1]}}, dividend[HALF-1:0]}
                          : {{HALF{1'b0}}, dividend[HALF-1:0]};
            eb      = sgn ? {{HALF{divisor[HALF-1]}}, divisor[HALF-1:0]}
                          : {{HALF{1'b0}}, divisor[HALF-1:0]};
            min_eff = {{(HALF+1){1'b1}}, {(HALF-1){1'b0}}};
        end else begin
            ea      = dividend;
            eb      = divisor;
            min_eff = {1'b1, {(W-1){1'b0}}};
        end
    end

    // Work out the signs and the magnitudes the unsigned core will divide.
    always_comb begin
        neg_a = sgn & ea[W-1];
        neg_b = sgn & eb[W-1];
        mag_a = neg_a ? (~ea + 1'b1) : ea;
        mag_b = neg_b ? (~eb + 1'b1) : eb;
    end

    // Detect the two cases whose result is fixed and give that result.
    always_comb begin
        b_zero = (eb == '0);
        ovf    = sgn & (ea == min_eff) & (eb == '1);
        if (b_zero) begin
            special_val = is_rem ? ea : '1;
        end else if (is_rem) begin
            special_val = '0;
        end else begin
            special_val = min_eff;
        end
        op.word    = word;
        op.is_rem  = is_rem;
        op.q_neg   = neg_a ^ neg_b;
        op.r_neg   = neg_a;
        op.special = b_zero | ovf;
    end

endmodule

// File: rtl/div_ctrl.sv
// Sequencer.
// Accepts a request when idle. It then runs W or W/2 iterations, or none
// for a fixed-result case, and gives a one-cycle result strobe before
// going idle again. Assumes W is a power of two, at least 4.
module div_ctrl
    import div_pkg::*;
#(
    parameter int W = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic word,
    input  logic special,
    output logic req_ready,
    output logic load,
    output logic step,
    output logic rsp_valid
);
    localparam int HALF = W / 2;
    localparam int CW   = $clog2(W);

    div_state_e    state;
    logic [CW-1:0] cnt;

    // Decode the handshake and datapath enables from the state.
    always_comb begin
        req_ready = (state == ST_IDLE);
        load      = req_valid & (state == ST_IDLE);
        step      = (state == ST_RUN);
        rsp_valid = (state == ST_FIN);
    end

    // Advance the state and the iteration counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state <= special ? ST_FIN : ST_RUN;
                        cnt   <= word ? CW'(HALF - 1) : CW'(W - 1);
                    end
                end
                ST_RUN: begin
                    if (cnt == '0) begin
                        state <= ST_FIN;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/div_iter.sv
// Radix-2 restoring divider on unsigned magnitudes.
// One quotient bit per step. For the word form the dividend is loaded
// into the upper half of the shift register, so W/2 steps are enough.
// Assumes mag_b is non-zero whenever steps are taken.
module div_iter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         word,
    input  logic [W-1:0] mag_a,
    input  logic [W-1:0] mag_b,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int HALF = W / 2;

    logic [W-1:0] q_r;
    logic [W-1:0] r_r;
    logic [W-1:0] d_r;
    logic [W:0]   shifted;
    logic         ge;
    logic [W-1:0] sub;

    // Trial subtraction of the divisor from the shifted partial remainder.
    always_comb begin
        shifted = {r_r, q_r[W-1]};
        ge      = (shifted >= {1'b0, d_r});
        sub     = shifted[W-1:0] - d_r;
    end

    // Load the operands, or take one quotient bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r <= '0;
            r_r <= '0;
            d_r <= '0;
        end else if (load) begin
            q_r <= word ? {mag_a[HALF-1:0], {HALF{1'b0}}} : mag_a;
            r_r <= '0;
            d_r <= mag_b;
        end else if (step) begin
            q_r <= {q_r[W-2:0], ge};
            r_r <= ge ? sub : shifted[W-1:0];
        end
    end

    assign quo = q_r;
    assign rem = r_r;

endmodule

// File: rtl/div_post.sv
// Result formation.
// Applies the sign fix-up to the quotient or remainder, or picks the fixed
// result, then sign-extends bit W/2-1 for the word form. Combinational.
module div_post
    import div_pkg::*;
#(
    parameter int W = 64
) (
    input  div_op_t      op,
    input  logic [W-1:0] quo,
    input  logic [W-1:0] rem,
    input  logic [W-1:0] special_val,
    output logic [W-1:0] result
);
    localparam int HALF = W / 2;

    logic [W-1:0] mag;
    logic         neg;
    logic [W-1:0] signed_val;
    logic [W-1:0] pick;

    // Choose, correct and size the final value.
    always_comb begin
        mag        = op.is_rem ? rem : quo;
        neg        = op.is_rem ? op.r_neg : op.q_neg;
        signed_val = neg ? (~mag + 1'b1) : mag;
        pick       = op.special ? special_val : signed_val;
        result     = op.word ? {{HALF{pick[HALF-1]}}, pick[HALF-1:0]} : pick;
    end

endmodule

// File: rtl/div_unit.sv
// Integer divide and remainder unit, top level.
// Takes one request at a time and returns a single-cycle result strobe.
// Function code bit 2 is set for all defined codes and is not decoded.
// Assumes W is a power of two, at least 4.
module div_unit
    import div_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    output logic         req_ready,
    input  logic [2:0]   req_func,
    input  logic         req_word,
    input  logic [W-1:0] req_dividend,
    input  logic [W-1:0] req_divisor,
    output logic         rsp_valid,
    output logic [W-1:0] rsp_result
);
    logic         func_msb_unused;
    logic [W-1:0] mag_a;
    logic [W-1:0] mag_b;
    div_op_t      op_in;
    div_op_t      op_q;
    logic [W-1:0] spec_in;
    logic [W-1:0] spec_q;
    logic         load;
    logic         step;
    logic [W-1:0] quo;
    logic [W-1:0] rem;
    logic [W-1:0] post_out;

    assign func_msb_unused = req_func[2];

    div_prep #(.W(W)) u_prep (
        .func_lo     (req_func[1:0]),
        .word        (req_word),
        .dividend    (req_dividend),
        .divisor     (req_divisor),
        .mag_a       (mag_a),
        .mag_b       (mag_b),
        .op          (op_in),
        .special_val (spec_in)
    );

    div_ctrl #(.W(W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .word      (req_word),
        .special   (op_in.special),
        .req_ready (req_ready),
        .load      (load),
        .step      (step),
        .rsp_valid (rsp_valid)
    );

    div_iter #(.W(W)) u_iter (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .word  (req_word),
        .mag_a (mag_a),
        .mag_b (mag_b),
        .quo   (quo),
        .rem   (rem)
    );

    // Hold the attributes and fixed result of the accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= '0;
            spec_q <= '0;
        end else if (load) begin
            op_q   <= op_in;
            spec_q <= spec_in;
        end
    end

    div_post #(.W(W)) u_post (
        .op          (op_q),
        .quo         (quo),
        .rem         (rem),
        .special_val (spec_q),
        .result      (post_out)
    );

    assign rsp_result = rsp_valid ? post_out : '0;

endmodule

// File: rtl/div_unit_chk.sv
// Protocol and corner-case checker for div_unit, bound to every instance.
// It observes only the ports and keeps its own record of each accepted
// operation.
module div_unit_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic         req_valid,
    input logic         req_ready,
    input logic [2:0]   req_func,
    input logic         req_word,
    input logic [W-1:0] req_dividend,
    input logic [W-1:0] req_divisor,
    input logic         rsp_valid,
    input logic [W-1:0] rsp_result
);
    localparam int HALF = W / 2;
    localparam int KW   = $clog2(W) + 2;

    logic          accept;
    logic          b_zero;
    logic          ovf;
    logic          zdiv_q;
    logic          early_q;
    logic          word_q;
    logic          busy;
    logic [KW-1:0] cyc;
    logic          func_msb_unused;

    assign func_msb_unused = req_func[2];

    // Classify the request at the ports.
    always_comb begin
        accept = req_valid & req_ready;
        if (req_word) begin
            b_zero = (req_divisor[HALF-1:0] == '0);
            ovf    = ~req_func[0]
                   & (req_dividend[HALF-1:0] == {1'b1, {(HALF-1){1'b0}}})
                   & (req_divisor[HALF-1:0] == '1);
        end else begin
            b_zero = (req_divisor == '0);
            ovf    = ~req_func[0]
                   & (req_dividend == {1'b1, {(W-1){1'b0}}})
                   & (req_divisor == '1);
        end
    end

    // Record the accepted operation and count the edges until its result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zdiv_q  <= 1'b0;
            early_q <= 1'b0;
            word_q  <= 1'b0;
            busy    <= 1'b0;
            cyc     <= '0;
        end else if (accept) begin
            zdiv_q  <= b_zero & ~req_func[1];
            early_q <= b_zero | ovf;
            word_q  <= req_word;
            busy    <= 1'b1;
            cyc     <= '0;
        end else if (busy) begin
            cyc <= cyc + 1'b1;
            if (rsp_valid) busy <= 1'b0;
        end
    end

    // R8
    ready_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && rsp_valid));

    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R8
    ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);

    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    // R3
    zero_quotient_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && zdiv_q) |-> (rsp_result == '1));

    // R7
    word_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && word_q) |-> (rsp_result[W-1:HALF] == {HALF{rsp_result[HALF-1]}}));

    // R9
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (cyc == (early_q ? KW'(0) : (word_q ? KW'(HALF) : KW'(W)))));

endmodule

bind div_unit div_unit_chk #(.W(W)) u_div_unit_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_func     (req_func),
    .req_word     (req_word),
    .req_dividend (req_dividend),
    .req_divisor  (req_divisor),
    .rsp_valid    (rsp_valid),
    .rsp_result   (rsp_result)
);

// File: tb/tb_div_unit.sv
`timescale 1ns/1ps
// Directed bench for div_unit: one task per scenario, each checking its own results.
module tb_div_unit;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [2:0]   req_func = 3'b100;
    logic         req_word = 1'b0;
    logic [W-1:0] req_dividend = '0;
    logic [W-1:0] req_divisor = '0;
    logic         rsp_valid;
    logic [W-1:0] rsp_result;

    int n_tests = 0;
    int n_fail  = 0;

    localparam logic [2:0] F_DIV  = 3'b100;
    localparam logic [2:0] F_DIVU = 3'b101;
    localparam logic [2:0] F_REM  = 3'b110;
    localparam logic [2:0] F_REMU = 3'b111;

    always #2.5 clk = ~clk;

    div_unit #(.W(W)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_func     (req_func),
        .req_word     (req_word),
        .req_dividend (req_dividend),
        .req_divisor  (req_divisor),
        .rsp_valid    (rsp_valid),
        .rsp_result   (rsp_result)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Reference result computed from the requirements.
    function automatic logic [63:0] ref_res(input logic [2:0] f, input logic w,
                                            input logic [63:0] a, input logic [63:0] b);
        logic sgn, isrem;
        logic [31:0] r32;
        logic [63:0] r64;
        logic signed [31:0] sa32, sb32;
        logic signed [63:0] sa64, sb64;
        sgn   = !f[0];
        isrem = f[1];
        if (w) begin
            sa32 = a[31:0];
            sb32 = b[31:0];
            if (b[31:0] == 32'd0)
                r32 = isrem ? a[31:0] : 32'hFFFF_FFFF;
            else if (sgn && a[31:0] == 32'h8000_0000 && b[31:0] == 32'hFFFF_FFFF)
                r32 = isrem ? 32'd0 : 32'h8000_0000;
            else if (sgn)
                r32 = isrem ? sa32 % sb32 : sa32 / sb32;
            else
                r32 = isrem ? a[31:0] % b[31:0] : a[31:0] / b[31:0];
            return {{32{r32[31]}}, r32};
        end
        sa64 = a;
        sb64 = b;
        if (b == 64'd0)
            r64 = isrem ? a : '1;
        else if (sgn && a == 64'h8000_0000_0000_0000 && b == '1)
            r64 = isrem ? 64'd0 : 64'h8000_0000_0000_0000;
        else if (sgn)
            r64 = isrem ? sa64 % sb64 : sa64 / sb64;
        else
            r64 = isrem ? a % b : a / b;
        return r64;
    endfunction

    // Expected number of edges from acceptance to the result strobe.
    function automatic int ref_lat(input logic [2:0] f, input logic w,
                                   input logic [63:0] a, input logic [63:0] b);
        if (w) begin
            if (b[31:0] == 0) return 0;
            if (!f[0] && a[31:0] == 32'h8000_0000 && b[31:0] == 32'hFFFF_FFFF) return 0;
            return 32;
        end
        if (b == 0) return 0;
        if (!f[0] && a == 64'h8000_0000_0000_0000 && b == '1) return 0;
        return 64;
    endfunction

    // Issue one operation from a negedge and check its result and latency.
    // With hold set, req_valid stays high during the busy period. Random
    // operands are driven first, then the follow-on operation hf/hw/ha/hb.
    task automatic do_op(input logic [2:0] f, input logic w, input logic [63:0] a,
                         input logic [63:0] b, input bit hold, input logic [2:0] hf,
                         input logic hw, input logic [63:0] ha, input logic [63:0] hb,
                         input string tag);
        int n;
        bit busy_ok;
        req_valid = 1'b1;
        req_func = f;
        req_word = w;
        req_dividend = a;
        req_divisor = b;
        chk("R8 ready before accept", {63'd0, req_ready}, 64'd1);
        @(posedge clk);
        @(negedge clk);
        n = 0;
        busy_ok = 1'b1;
        while (!rsp_valid && n < 200) begin
            if (req_ready) busy_ok = 1'b0;
            if (hold) begin
                req_valid = 1'b1;
                if (n < 10) begin
                    req_func = 3'b100 | 3'($urandom_range(0, 3));
                    req_word = 1'($urandom_range(0, 1));
                    req_dividend = {$urandom, $urandom};
                    req_divisor = {$urandom, $urandom};
                end else begin
                    req_func = hf;
                    req_word = hw;
                    req_dividend = ha;
                    req_divisor = hb;
                end
            end else begin
                req_valid = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        chk({tag, " result"}, rsp_result, ref_res(f, w, a, b));
        chk("R9 latency", 64'(n), 64'(ref_lat(f, w, a, b)));
        chk("R8 ready low while busy", {63'd0, busy_ok}, 64'd1);
        if (hold) begin
            req_func = hf;
            req_word = hw;
            req_dividend = ha;
            req_divisor = hb;
        end else begin
            req_valid = 1'b0;
        end
        @(negedge clk);
        chk("R8 strobe single cycle", {63'd0, rsp_valid}, 64'd0);
        chk("R8 ready after result", {63'd0, req_ready}, 64'd1);
    endtask

    task automatic run(input logic [2:0] f, input logic w, input logic [63:0] a,
                       input logic [63:0] b, input string tag);
        do_op(f, w, a, b, 1'b0, 3'b100, 1'b0, 64'd0, 64'd0, tag);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset ready", {63'd0, req_ready}, 64'd1);
        chk("R8 reset strobe", {63'd0, rsp_valid}, 64'd0);
    endtask

    task automatic t_codes;
        run(F_DIV,  1'b0, 64'd100, 64'd7, "R1 signed quotient");
        run(F_DIVU, 1'b0, 64'hFFFF_FFFF_FFFF_FFF0, 64'd3, "R1 unsigned quotient");
        run(F_REM,  1'b0, 64'd100, 64'd7, "R1 signed remainder");
        run(F_REMU, 1'b0, 64'hFFFF_FFFF_FFFF_FFF0, 64'd7, "R1 unsigned remainder");
        run(F_DIV,  1'b0, -64'sd100, 64'd7, "R2 negative dividend quotient");
        run(F_REM,  1'b0, -64'sd100, 64'd7, "R2 negative dividend remainder");
        run(F_DIV,  1'b0, 64'd100, -64'sd7, "R2 negative divisor quotient");
        run(F_REM,  1'b0, 64'd100, -64'sd7, "R2 negative divisor remainder");
        run(F_DIV,  1'b0, -64'sd100, -64'sd7, "R2 both negative quotient");
        run(F_REM,  1'b0, -64'sd100, -64'sd7, "R2 both negative remainder");
        run(F_DIVU, 1'b0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R2 unsigned large divisor");
        run(F_DIVU, 1'b0, 64'hDEAD_BEEF_0123_4567, 64'h0000_0001_0000_0001, "R2 unsigned pattern");
        run(F_REM,  1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, "R2 divide by one");
    endtask

    task automatic t_div_zero;
        run(F_DIV,  1'b0, 64'h1234_5678_9ABC_DEF0, 64'd0, "R3 signed quotient by zero");
        run(F_DIVU, 1'b0, 64'd5, 64'd0, "R3 unsigned quotient by zero");
        run(F_DIV,  1'b1, 64'd5, 64'hFFFF_FFFF_0000_0000, "R3 word quotient by zero");
        run(F_DIVU, 1'b1, 64'd5, 64'h0000_0001_0000_0000, "R3 word unsigned quotient by zero");
        run(F_REM,  1'b0, -64'sd9, 64'd0, "R4 signed remainder by zero");
        run(F_REMU, 1'b0, 64'hFEDC_BA98_7654_3210, 64'd0, "R4 unsigned remainder by zero");
        run(F_REM,  1'b1, 64'h1111_1111_8765_4321, 64'd0, "R4 word remainder by zero");
        run(F_REMU, 1'b1, 64'h1234_5678_8765_4321, 64'd0, "R4 word unsigned remainder by zero");
    endtask

    task automatic t_overflow;
        run(F_DIV, 1'b0, 64'h8000_0000_0000_0000, '1, "R5 full overflow quotient");
        run(F_REM, 1'b0, 64'h8000_0000_0000_0000, '1, "R5 full overflow remainder");
        run(F_DIV, 1'b1, 64'h0000_0042_8000_0000, 64'h0000_0000_FFFF_FFFF, "R5 word overflow quotient");
        run(F_REM, 1'b1, 64'hABCD_0000_8000_0000, 64'h1234_5678_FFFF_FFFF, "R5 word overflow remainder");
        run(F_REM, 1'b0, 64'd7, '1, "R5 remainder by minus one");
        run(F_DIVU, 1'b0, 64'h8000_0000_0000_0000, '1, "R5 unsigned form is no overflow");
    endtask

    task automatic t_word;
        run(F_DIVU, 1'b1, 64'h5555_5555_FFFF_FFFF, 64'hAAAA_AAAA_0000_0001, "R7 unsigned word sign extension");
        run(F_REMU, 1'b1, 64'h0000_0001_F000_0007, 64'h7777_0000_8000_0000, "R7 unsigned word remainder extension");
        run(F_DIV,  1'b1, 64'hFFFF_FFFF_0000_0064, 64'h0000_0000_FFFF_FFF9, "R6 word signed quotient");
        run(F_REM,  1'b1, 64'h1234_0000_FFFF_FF9C, 64'hFFFF_0000_0000_0007, "R6 word signed remainder");
        run(F_DIVU, 1'b1, 64'h8000_0000_0000_0010, 64'h8000_0000_0000_0003, "R6 upper bits ignored");
    endtask

    task automatic t_busy;
        do_op(F_DIV, 1'b0, -64'sd1000, 64'd13, 1'b1,
              F_REMU, 1'b1, 64'h9999_0000_0000_0064, 64'h0000_0000_0000_0009,
              "R10 first result with inputs changing");
        chk("R10 held request not taken in result cycle", {63'd0, req_ready}, 64'd1);
        do_op(F_REMU, 1'b1, 64'h9999_0000_0000_0064, 64'h0000_0000_0000_0009, 1'b0,
              3'b100, 1'b0, 64'd0, 64'd0, "R10 held request taken afterwards");
        do_op(F_DIVU, 1'b1, 64'd0, 64'd0, 1'b1,
              F_DIV, 1'b0, 64'd77, 64'd11, "R10 early result with request held");
        do_op(F_DIV, 1'b0, 64'd77, 64'd11, 1'b0,
              3'b100, 1'b0, 64'd0, 64'd0, "R10 follow-on after early result");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R9 watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_codes();
        t_div_zero();
        t_overflow();
        t_word();
        t_busy();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule